// File: doc/BRIEF.md
# Timer Interrupt Pending Flag with Acknowledge-on-Read

This block turns single-cycle timer ticks into a sticky pending flag that drives an active-high fast interrupt request. Software acknowledges the interrupt by reading a status location. That read returns the flag in the top data bit and clears the flag in the same access. A separate write-only location holds a mask bit that can stop the timer from interrupting the processor.

A debugger may need to inspect the status location without disturbing the running program. A qualifier input marks a read as such a peek. A peek returns the same data as a normal read but leaves the flag and the request line as they were. The tick divider sits outside this block, and so does the bus address decoder. The decoder supplies one select per location together with the read and write strobes.

Top module: `tirq_flag`

## Requirements
- R1: A read with the status select returns the pending flag in bit 7 (0x80 when pending, 0x00 when not), and bits 6..0 read as zero. When no status read is in progress, the read data is all zeros.
- R2: A read of the status location without the peek qualifier clears the pending flag at that clock edge, so the interrupt line is low in the following cycle.
- R3: A status read with the peek qualifier high returns the flag and leaves both the flag and the interrupt line unchanged.
- R4: A write to the mask location stores data bit 7 as the mask (1 = prohibit) and ignores bits 6..0. The mask location is write-only, so a read with the mask select returns zero.
- R5: When the mask is clear, a tick sets the pending flag, and the interrupt line is high in the cycle after the tick.
- R6: Once a write sets the mask, the interrupt line is low from the next cycle on. A flag that was already pending is kept, still shows in the status data, and raises the line again when the mask is cleared.
- R7: A tick that arrives while the mask is set does not set the pending flag.
- R8: When an unmasked tick and a clearing status read fall in the same cycle, the flag remains set and the line stays high.
- R9: Reset clears the flag and the mask and holds the interrupt line low.
- R10: A write with the status select has no effect on the flag or the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timer tick pulse |
| st_sel_i | input | 1 | Selects the status location |
| msk_sel_i | input | 1 | Selects the mask location |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| peek_i | input | 1 | Marks a read as a debugger peek with no side effect |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from the selects and state |
| irq_o | output | 1 | Fast interrupt request, active high |

## Verification
A timer tick and an acknowledging status read can fall in the same cycle. In that case the set from the tick and the clear from the read conflict at a single edge. The bench drives a tick together with a non-peek status read while the flag is already pending. It then checks that the read data reports the flag and that the line is still high in the next cycle. A follow-up peek confirms that the flag survived. A second overlap, a tick arriving in the cycle after a mask write, is judged by a later peek that must show no flag.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    // Decoded bus actions for one cycle
    typedef struct packed {
        logic status_rd;   // status location is being read (peek or not)
        logic status_clr;  // status read that acknowledges
        logic mask_wr;     // mask location is being written
    } tirq_cmd_t;

    typedef struct packed {
        logic mask;
    } tirq_mask_state_t;

    typedef struct packed {
        logic pend;
    } tirq_pend_state_t;

endpackage

// File: rtl/tirq_decode.sv
module tirq_decode
    import tirq_pkg::*;
(
    input  logic      st_sel_i,
    input  logic      msk_sel_i,
    input  logic      rd_i,
    input  logic      wr_i,
    input  logic      peek_i,
    output tirq_cmd_t cmd_o
);

    always_comb begin
        cmd_o            = '0;
        cmd_o.status_rd  = st_sel_i & rd_i;
        cmd_o.status_clr = st_sel_i & rd_i & ~peek_i;
        cmd_o.mask_wr    = msk_sel_i & wr_i;
    end

endmodule

// File: rtl/tirq_mask.sv
module tirq_mask
    import tirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mask_wr_i,
    input  logic mask_bit_i,
    output logic mask_o
);

    tirq_mask_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (mask_wr_i) begin
            state_d.mask = mask_bit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o = state_q.mask;

    AST_MASK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (mask_o == $past(mask_bit_i)));  // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(mask_o));  // R4

endmodule

// File: rtl/tirq_pending.sv
module tirq_pending
    import tirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic mask_i,
    input  logic clr_i,
    input  logic peek_rd_i,
    output logic pend_o
);

    tirq_pend_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.pend = 1'b0;
        end
        // an accepted tick overrides a simultaneous acknowledge
        if (tick_i && !mask_i) begin
            state_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_o = state_q.pend;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !tick_i) |=> !pend_o);  // R2

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_rd_i && !clr_i && !tick_i) |=> $stable(pend_o));  // R3

    AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !mask_i) |=> pend_o);  // R5

    AST_MASKED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> !$rose(pend_o));  // R7

endmodule

// File: rtl/tirq_flag.sv
module tirq_flag
    import tirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              st_sel_i,
    input  logic              msk_sel_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              peek_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int FLAG_BIT = DATA_W - 1;

    tirq_cmd_t cmd;
    logic      mask_q;
    logic      pend_q;
    logic      unused_wdata_low;

    assign unused_wdata_low = ^wdata_i[FLAG_BIT-1:0];

    tirq_decode u_decode (
        .st_sel_i (st_sel_i),
        .msk_sel_i(msk_sel_i),
        .rd_i     (rd_i),
        .wr_i     (wr_i),
        .peek_i   (peek_i),
        .cmd_o    (cmd)
    );

    tirq_mask u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr_i (cmd.mask_wr),
        .mask_bit_i(wdata_i[FLAG_BIT]),
        .mask_o    (mask_q)
    );

    tirq_pending u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .mask_i   (mask_q),
        .clr_i    (cmd.status_clr),
        .peek_rd_i(cmd.status_rd),
        .pend_o   (pend_q)
    );

    always_comb begin
        rdata_o = '0;
        if (cmd.status_rd) begin
            rdata_o[FLAG_BIT] = pend_q;
        end
    end

    assign irq_o = pend_q & ~mask_q;

    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_sel_i && rd_i && !peek_i && !tick_i) |=> !irq_o);  // R2

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_sel_i && wr_i && wdata_i[FLAG_BIT]) |=> !irq_o);  // R6

    AST_RACE_TICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !mask_q && !(msk_sel_i && wr_i && wdata_i[FLAG_BIT])) |=> irq_o);  // R8

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_sel_i && rd_i) |-> (rdata_o == '0));  // R1

endmodule

// File: tb/tirq_flag_bench.sv
module tirq_flag_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          st_sel_i = 1'b0;
    logic          msk_sel_i = 1'b0;
    logic          rd_i = 1'b0;
    logic          wr_i = 1'b0;
    logic          peek_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tirq_flag #(.DATA_W(DW)) u_tirq_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .st_sel_i (st_sel_i),
        .msk_sel_i(msk_sel_i),
        .rd_i     (rd_i),
        .wr_i     (wr_i),
        .peek_i   (peek_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .irq_o    (irq_o)
    );

    // fields: req[4] tick st msk rd wr peek wdata[8] exp_rdata[8] exp_irq
    localparam int NV = 20;
    localparam logic [26:0] VEC [NV] = '{
        {4'd9,  6'b000000, 8'h00, 8'h00, 1'b0},  // idle after reset
        {4'd5,  6'b100000, 8'h00, 8'h00, 1'b1},  // tick
        {4'd3,  6'b010101, 8'h00, 8'h80, 1'b1},  // peek
        {4'd2,  6'b010100, 8'h00, 8'h80, 1'b0},  // acknowledge
        {4'd1,  6'b010100, 8'h00, 8'h00, 1'b0},  // read empty
        {4'd5,  6'b100000, 8'h00, 8'h00, 1'b1},  // tick
        {4'd8,  6'b110100, 8'h00, 8'h80, 1'b1},  // tick + acknowledge
        {4'd6,  6'b001010, 8'h80, 8'h00, 1'b0},  // set mask
        {4'd6,  6'b010101, 8'h00, 8'h80, 1'b0},  // flag kept
        {4'd2,  6'b010100, 8'h00, 8'h80, 1'b0},  // acknowledge
        {4'd7,  6'b100000, 8'h00, 8'h00, 1'b0},  // masked tick
        {4'd7,  6'b010101, 8'h00, 8'h00, 1'b0},  // flag not set
        {4'd4,  6'b001010, 8'h7F, 8'h00, 1'b0},  // clear mask, low bits ones
        {4'd5,  6'b100000, 8'h00, 8'h00, 1'b1},  // tick
        {4'd4,  6'b001100, 8'h00, 8'h00, 1'b1},  // mask read is zero
        {4'd10, 6'b010010, 8'hFF, 8'h00, 1'b1},  // write to status
        {4'd10, 6'b010101, 8'h00, 8'h80, 1'b1},  // flag unchanged
        {4'd6,  6'b001010, 8'h80, 8'h00, 1'b0},  // mask while pending
        {4'd6,  6'b001010, 8'h00, 8'h00, 1'b1},  // unmask re-raises
        {4'd1,  6'b010100, 8'h00, 8'h80, 1'b0}   // final acknowledge
    };

    function automatic string rtag(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] ctl, input logic [DW-1:0] wd);
        {tick_i, st_sel_i, msk_sel_i, rd_i, wr_i, peek_i} = ctl;
        wdata_i = wd;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", "irq in reset", {7'd0, irq_o}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][22:17], VEC[i][16:9]);
            #1;
            check(rtag(VEC[i][26:23]), "rdata", rdata_o, VEC[i][8:1]);
            @(posedge clk);
            #1;
            check(rtag(VEC[i][26:23]), "irq", {7'd0, irq_o}, {7'd0, VEC[i][0]});
        end

        // directed: reset while pending and masked
        @(negedge clk); drive(6'b100000, 8'h00);
        @(negedge clk); drive(6'b001010, 8'h80);
        @(negedge clk); drive(6'b000000, 8'h00);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R9", "irq during reset", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        drive(6'b010101, 8'h00);
        #1;
        check("R9", "flag after reset", rdata_o, 8'h00);
        @(negedge clk); drive(6'b100000, 8'h00);
        @(posedge clk); #1;
        check("R9", "mask cleared by reset", {7'd0, irq_o}, 8'h01);

        // directed: tick in the cycle right after a mask write
        @(negedge clk); drive(6'b010100, 8'h00);
        @(negedge clk); drive(6'b001010, 8'h80);
        @(negedge clk); drive(6'b100000, 8'h00);
        @(negedge clk); drive(6'b010101, 8'h00);
        #1;
        check("R7", "tick after mask write", rdata_o, 8'h00);
        @(negedge clk); drive(6'b000000, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule